// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a processor core that completes one 32-bit instruction in each clock cycle. The instruction address goes out on one port and the instruction word comes back combinationally. The data side has an address, write data, a write enable and read data. The core holds the program counter, a 32-entry register file, an ALU and the next-PC logic. Its control has two levels. An opcode decoder picks a 2-bit ALU class. That class either forces an add, forces a subtract, or hands the choice to a decoder of the funct field.

The core supports register-register add, sub, and, or and set-less-than, and also immediate add, word load, word store, branch-if-equal and an absolute jump. Opcodes and funct codes that are not in this set act as no-ops: no register write, no memory write, and the PC advances by 4. Both memories sit outside the core and are modelled by whatever surrounds it.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, the PC is asynchronously held at 0x00000000, so imem_addr_o is 0. The instruction at address 0 executes in the first cycle after release.
- R2: Unless a taken branch or a jump applies, the next PC is PC+4. Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], funct[5:0], imm[15:0] and jump address[25:0].
- R3: Op 0x00 writes rd with rs op rt. The funct codes are 0x20 add, 0x22 subtract (rs-rt), 0x24 AND, 0x25 OR and 0x2A set-less-than. Set-less-than yields bit 31 of rs-rt, zero-extended.
- R4: Op 0x08 writes rt with rs plus the 16-bit immediate sign-extended to 32 bits.
- R5: Op 0x23 writes rt with dmem_rdata_i, read at address rs+sext(imm).
- R6: Op 0x2B drives dmem_addr_o = rs+sext(imm) and dmem_wdata_o = rt, and raises dmem_we_o for that cycle only.
- R7: Op 0x04 with rs==rt sets the next PC to PC+4+(sext(imm)<<2). Negative offsets branch backwards. With rs!=rt the next PC is PC+4.
- R8: Op 0x02 sets the next PC to {PC+4 bits [31:28], address[25:0], 2'b00}.
- R9: Register 0 always reads as zero, and a write aimed at it is discarded.
- R10: An unknown opcode, or op 0x00 with an unknown funct, writes no register, does not raise dmem_we_o, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction fetch address (PC) |
| imem_rdata_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data memory address (ALU result) |
| dmem_wdata_o | output | 32 | Store data (rt value) |
| dmem_we_o | output | 1 | Data memory write enable |
| dmem_rdata_i | input | 32 | Data memory read data at dmem_addr_o |

## Verification
The hardest part to observe is what must not happen. A write to register 0, or a write from an illegal opcode or funct, leaves no trace at the ports when it occurs. The program therefore first loads known values into those registers. It then issues the suspect instructions, and later stores the registers so that any corruption shows up on dmem_wdata_o. The program also includes a backward branch that lands between two jumps, so that a wrong sign or shift in the branch offset changes the fetch sequence that the scoreboard compares cycle by cycle.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned FN_W    = 6;
  localparam int unsigned RA_W    = 5;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned JADDR_W = 26;

  typedef enum logic [OP_W-1:0] {
    OP_RTYPE = 6'h00,
    OP_J     = 6'h02,
    OP_BEQ   = 6'h04,
    OP_ADDI  = 6'h08,
    OP_LW    = 6'h23,
    OP_SW    = 6'h2B
  } opcode_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 6'h20,
    FN_SUB = 6'h22,
    FN_AND = 6'h24,
    FN_OR  = 6'h25,
    FN_SLT = 6'h2A
  } funct_e;

  // ALU class chosen by the opcode decoder
  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  // bit 2 = invert B with carry-in, bits 1:0 = result select
  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     src_imm;
    logic     branch;
    logic     mem_we;
    logic     wb_mem;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{
    reg_we: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, branch: 1'b0,
    mem_we: 1'b0, wb_mem: 1'b0, jump: 1'b0, cls: CLS_ADD
  };
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_core_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o,
  output logic            op_ok_o
);
  always_comb begin
    ctrl_o  = CTRL_NOP;
    op_ok_o = 1'b1;
    case (op_i)
      OP_RTYPE: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.dst_rd = 1'b1;
        ctrl_o.cls    = CLS_FUNCT;
      end
      OP_LW: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.wb_mem  = 1'b1;
      end
      OP_SW: begin
        ctrl_o.src_imm = 1'b1;
        ctrl_o.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.cls    = CLS_SUB;
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.src_imm = 1'b1;
      end
      OP_J: begin
        ctrl_o.jump = 1'b1;
      end
      default: op_ok_o = 1'b0;  // no-op
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_core_pkg::*;
(
  input  alu_cls_e        cls_i,
  input  logic [FN_W-1:0] funct_i,
  output logic [2:0]      alu_op_o,
  output logic            funct_ok_o
);
  always_comb begin
    alu_op_o   = ALU_ADD;
    funct_ok_o = 1'b1;
    case (cls_i)
      CLS_ADD: alu_op_o = ALU_ADD;
      CLS_SUB: alu_op_o = ALU_SUB;
      default: begin
        case (funct_i)
          FN_ADD:  alu_op_o = ALU_ADD;
          FN_SUB:  alu_op_o = ALU_SUB;
          FN_AND:  alu_op_o = ALU_AND;
          FN_OR:   alu_op_o = ALU_OR;
          FN_SLT:  alu_op_o = ALU_SLT;
          default: funct_ok_o = 1'b0;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;

  assign b_eff = op_i[2] ? ~b_i : b_i;
  assign sum   = a_i + b_eff + {{(W-1){1'b0}}, op_i[2]};

  always_comb begin
    case (op_i[1:0])
      2'b00:   y_o = a_i & b_eff;
      2'b01:   y_o = a_i | b_eff;
      2'b10:   y_o = sum;
      default: y_o = {{(W-1){1'b0}}, sum[W-1]};
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned W  = 32,
  parameter int unsigned N  = 32,
  parameter int unsigned RP = 2,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [RP-1:0][AW-1:0] ra_i,
  output logic [RP-1:0][W-1:0]  rd_o,
  input  logic                  we_i,
  input  logic [AW-1:0]         wa_i,
  input  logic [W-1:0]          wd_i
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs[wa_i] <= wd_i;
    end
  end

  for (genvar p = 0; p < RP; p++) begin : g_rd
    assign rd_o[p] = (ra_i[p] == '0) ? '0 : regs[ra_i[p]];
  end
endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc
  import sc_core_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]       pc_i,
  input  logic [W-1:0]       imm_i,
  input  logic [JADDR_W-1:0] jaddr_i,
  input  logic               take_br_i,
  input  logic               jump_i,
  output logic [W-1:0]       next_o
);
  localparam int unsigned SEG_W = W - JADDR_W - 2;

  logic [W-1:0] pc_plus4;
  logic [W-1:0] br_tgt;
  logic [W-1:0] jmp_tgt;

  assign pc_plus4 = pc_i + W'(4);
  assign br_tgt   = pc_plus4 + (imm_i << 2);
  assign jmp_tgt  = {pc_plus4[W-1 -: SEG_W], jaddr_i, 2'b00};

  always_comb begin
    if (jump_i)         next_o = jmp_tgt;
    else if (take_br_i) next_o = br_tgt;
    else                next_o = pc_plus4;
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_core_pkg::*;
#(
  parameter int unsigned    XLEN     = 32,
  parameter int unsigned    NREGS    = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  output logic            dmem_we_o,
  input  logic [XLEN-1:0] dmem_rdata_i
);
  localparam int unsigned RF_AW = $clog2(NREGS);

  logic [XLEN-1:0] pc_q, pc_d;

  logic [OP_W-1:0]    f_op;
  logic [RA_W-1:0]    f_rs, f_rt, f_rd;
  logic [FN_W-1:0]    f_fn;
  logic [IMM_W-1:0]   f_imm;
  logic [JADDR_W-1:0] f_jaddr;
  logic [4:0]         unused_shamt;

  assign f_op         = imem_rdata_i[31:26];
  assign f_rs         = imem_rdata_i[25:21];
  assign f_rt         = imem_rdata_i[20:16];
  assign f_rd         = imem_rdata_i[15:11];
  assign unused_shamt = imem_rdata_i[10:6];
  assign f_fn         = imem_rdata_i[5:0];
  assign f_imm        = imem_rdata_i[15:0];
  assign f_jaddr      = imem_rdata_i[25:0];

  ctrl_t      ctrl;
  logic       op_ok;
  logic [2:0] alu_op;
  logic       funct_ok;

  sc_main_dec u_main_dec (
    .op_i    (f_op),
    .ctrl_o  (ctrl),
    .op_ok_o (op_ok)
  );

  sc_alu_dec u_alu_dec (
    .cls_i      (ctrl.cls),
    .funct_i    (f_fn),
    .alu_op_o   (alu_op),
    .funct_ok_o (funct_ok)
  );

  // illegal funct suppresses the write of an otherwise valid R-type
  logic legal;
  assign legal = op_ok & ((ctrl.cls != CLS_FUNCT) | funct_ok);

  logic [XLEN-1:0] sext_imm;
  assign sext_imm = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

  logic [1:0][RF_AW-1:0] rf_ra;
  logic [1:0][XLEN-1:0]  rf_rd;
  logic [XLEN-1:0]       rs_val, rt_val;
  logic                  rf_we;
  logic [RF_AW-1:0]      rf_wa;
  logic [XLEN-1:0]       rf_wd;

  assign rf_ra[0] = RF_AW'(f_rs);
  assign rf_ra[1] = RF_AW'(f_rt);
  assign rs_val   = rf_rd[0];
  assign rt_val   = rf_rd[1];

  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_zero;

  assign alu_b = ctrl.src_imm ? sext_imm : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a_i    (rs_val),
    .b_i    (alu_b),
    .op_i   (alu_op),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign rf_we = ctrl.reg_we & legal;
  assign rf_wa = ctrl.dst_rd ? RF_AW'(f_rd) : RF_AW'(f_rt);
  assign rf_wd = ctrl.wb_mem ? dmem_rdata_i : alu_y;

  sc_regfile #(.W(XLEN), .N(NREGS), .RP(2)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (rf_ra),
    .rd_o   (rf_rd),
    .we_i   (rf_we),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd)
  );

  sc_next_pc #(.W(XLEN)) u_npc (
    .pc_i      (pc_q),
    .imm_i     (sext_imm),
    .jaddr_i   (f_jaddr),
    .take_br_i (ctrl.branch & alu_zero),
    .jump_i    (ctrl.jump),
    .next_o    (pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_d;
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_y;
  assign dmem_wdata_o = rt_val;
  assign dmem_we_o    = ctrl.mem_we;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_core_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] imem_addr_o,
  input logic [XLEN-1:0] imem_rdata_i,
  input logic [XLEN-1:0] dmem_addr_o,
  input logic [XLEN-1:0] dmem_wdata_o,
  input logic            dmem_we_o,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            rf_we
);
  logic [OP_W-1:0] op;
  logic [RA_W-1:0] rs;
  logic [FN_W-1:0] fn;
  logic [XLEN-1:0] sx, p4, br_tgt, j_tgt;
  logic            eq, fn_known, op_known;

  assign op     = imem_rdata_i[31:26];
  assign rs     = imem_rdata_i[25:21];
  assign fn     = imem_rdata_i[5:0];
  assign sx     = {{(XLEN-16){imem_rdata_i[15]}}, imem_rdata_i[15:0]};
  assign p4     = imem_addr_o + XLEN'(4);
  assign br_tgt = p4 + {sx[XLEN-3:0], 2'b00};
  assign j_tgt  = {p4[XLEN-1:28], imem_rdata_i[25:0], 2'b00};
  assign eq     = (rs_val == rt_val);
  assign fn_known = (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
                    (fn == FN_OR)  || (fn == FN_SLT);
  assign op_known = (op == OP_RTYPE) || (op == OP_J) || (op == OP_BEQ) ||
                    (op == OP_ADDI)  || (op == OP_LW) || (op == OP_SW);

  AST_PC_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op != OP_J && !(op == OP_BEQ && eq)) |=> imem_addr_o == $past(imem_addr_o) + XLEN'(4)); // R2

  AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_BEQ && eq) |=> imem_addr_o == $past(br_tgt)); // R7

  AST_JUMP_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_J) |=> imem_addr_o == $past(j_tgt)); // R8

  AST_STORE_PORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SW) |-> (dmem_we_o && dmem_addr_o == rs_val + sx && dmem_wdata_o == rt_val)); // R6

  AST_WE_ONLY_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_we_o |-> (op == OP_SW)); // R10

  AST_ZERO_REG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs == '0) |-> (rs_val == '0)); // R9

  AST_BAD_FUNCT_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_RTYPE && !fn_known) |-> !rf_we); // R10

  AST_BAD_OP_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_known |-> !rf_we); // R10
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .imem_addr_o  (imem_addr_o),
  .imem_rdata_i (imem_rdata_i),
  .dmem_addr_o  (dmem_addr_o),
  .dmem_wdata_o (dmem_wdata_o),
  .dmem_we_o    (dmem_we_o),
  .rs_val       (rs_val),
  .rt_val       (rt_val),
  .rf_we        (rf_we)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_core dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .imem_addr_o  (imem_addr),
    .imem_rdata_i (imem_rdata),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_we_o    (dmem_we),
    .dmem_rdata_i (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] i_ins(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] j_ins(int addr);
    return {6'h02, 26'(addr)};
  endfunction

  // scoreboard: one entry per executed cycle
  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic        ck_addr;
    logic [31:0] addr;
    logic [31:0] wd;
  } step_t;
  step_t sb_q[$];
  string tag_q[$];

  task automatic push(input logic [31:0] pc, input logic we, input logic ck,
                      input logic [31:0] addr, input logic [31:0] wd, input string tag);
    sb_q.push_back('{pc: pc, we: we, ck_addr: ck, addr: addr, wd: wd});
    tag_q.push_back(tag);
  endtask

  task automatic monitor();
    while (sb_q.size() > 0) begin
      step_t e;
      string t;
      bit ok;
      e = sb_q.pop_front();
      t = tag_q.pop_front();
      ok = (imem_addr === e.pc) && (dmem_we === e.we) &&
           (!(e.we || e.ck_addr) || dmem_addr === e.addr) &&
           (!e.we || dmem_wdata === e.wd);
      checks++;
      if (!ok) begin
        failures++;
        $display("FAIL %s pc=%h/%h we=%b/%b addr=%h/%h wd=%h/%h (actual/expected)",
                 t, imem_addr, e.pc, dmem_we, e.we, dmem_addr, e.addr, dmem_wdata, e.wd);
      end
      @(negedge clk); #1;
    end
    done = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end
    imem[0]  = i_ins(6'h08, 0, 1, 5);            // r1 = 5
    imem[1]  = i_ins(6'h08, 0, 2, -3);           // r2 = -3
    imem[2]  = r_ins(1, 2, 3, 6'h20);            // r3 = 2
    imem[3]  = r_ins(1, 2, 4, 6'h22);            // r4 = 8
    imem[4]  = r_ins(1, 2, 5, 6'h24);            // r5 = 5
    imem[5]  = r_ins(1, 2, 6, 6'h25);            // r6 = -3
    imem[6]  = r_ins(2, 1, 7, 6'h2A);            // r7 = 1
    imem[7]  = r_ins(1, 2, 8, 6'h2A);            // r8 = 0
    imem[8]  = i_ins(6'h08, 0, 10, 9);           // r10 = 9
    imem[9]  = i_ins(6'h08, 0, 0, 7);            // write to r0
    imem[10] = i_ins(6'h3F, 0, 10, 1);           // unknown opcode
    imem[11] = r_ins(1, 1, 10, 6'h00);           // unknown funct
    imem[12] = i_ins(6'h2B, 0, 3, 128);
    imem[13] = i_ins(6'h2B, 0, 4, 132);
    imem[14] = i_ins(6'h2B, 0, 5, 136);
    imem[15] = i_ins(6'h2B, 0, 6, 140);
    imem[16] = i_ins(6'h2B, 0, 7, 144);
    imem[17] = i_ins(6'h2B, 0, 8, 148);
    imem[18] = i_ins(6'h2B, 0, 0, 152);
    imem[19] = i_ins(6'h2B, 0, 10, 156);
    imem[20] = i_ins(6'h23, 0, 9, 128);          // r9 = mem[0x80]
    imem[21] = i_ins(6'h2B, 1, 9, 155);          // addr 5+155
    imem[22] = i_ins(6'h04, 1, 2, 5);            // not taken
    imem[23] = i_ins(6'h04, 1, 1, 1);            // taken -> 100
    imem[24] = i_ins(6'h2B, 0, 1, 0);            // skipped
    imem[25] = j_ins(30);                        // -> 120
    imem[26] = i_ins(6'h2B, 0, 1, 0);
    imem[27] = i_ins(6'h2B, 0, 1, 0);
    imem[28] = i_ins(6'h2B, 0, 2, 164);
    imem[29] = j_ins(31);                        // -> 124
    imem[30] = i_ins(6'h04, 0, 0, -3);           // backward -> 112
    imem[31] = j_ins(31);                        // halt

    push(32'd0, 0, 0, 0, 0, "R1");
    for (int i = 1; i < 10; i++) push(32'(4*i), 0, 0, 0, 0, "R2");
    push(32'd40, 0, 0, 0, 0, "R10");
    push(32'd44, 0, 0, 0, 0, "R10");
    push(32'd48, 1, 1, 32'h80, 32'd2, "R3 add");
    push(32'd52, 1, 1, 32'h84, 32'd8, "R3 sub");
    push(32'd56, 1, 1, 32'h88, 32'd5, "R3 and");
    push(32'd60, 1, 1, 32'h8C, 32'hFFFF_FFFD, "R3 or");
    push(32'd64, 1, 1, 32'h90, 32'd1, "R3 slt true");
    push(32'd68, 1, 1, 32'h94, 32'd0, "R3 slt false");
    push(32'd72, 1, 1, 32'h98, 32'd0, "R9");
    push(32'd76, 1, 1, 32'h9C, 32'd9, "R10 no write");
    push(32'd80, 0, 1, 32'h80, 0, "R5 address");
    push(32'd84, 1, 1, 32'hA0, 32'd2, "R5 R6");
    push(32'd88, 0, 0, 0, 0, "R7 not taken");
    push(32'd92, 0, 0, 0, 0, "R7");
    push(32'd100, 0, 0, 0, 0, "R7 taken");
    push(32'd120, 0, 0, 0, 0, "R8");
    push(32'd112, 1, 1, 32'hA4, 32'hFFFF_FFFD, "R7 backward R4");
    push(32'd116, 0, 0, 0, 0, "R6 single cycle");
    push(32'd124, 0, 0, 0, 0, "R8");
    push(32'd124, 0, 0, 0, 0, "R8 self");

    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++;
    if (imem_addr !== 32'd0 || dmem_we !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset pc=%h/%h we=%b/%b (actual/expected)", imem_addr, 32'd0, dmem_we, 1'b0);
    end
    rst_ni = 1'b1;
    #1;
    fork
      monitor();
      begin repeat (2000) @(posedge clk); end
    join_any
    disable fork;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: scoreboard left %0d/0 entries (actual/expected)", sb_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule